// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit-Slot Engine

This block is the slave-side timing engine for a single-wire, open-drain bus with a pull-up. A free-running one-microsecond strobe clocks all slot timing. A two-flop synchronizer cleans the sampled line. The engine then sorts each low excursion of the line into one of three cases:

- a reset pulse, which it answers with a presence pulse;
- a write slot, whose level it samples and hands to a byte-level controller;
- a read slot, in which it either holds the line low (to send a 0) or leaves it alone (to send a 1), as the controller asks.

Two speed profiles exist, standard and overdrive. Every window scales with the profile: the reset threshold, the presence delay and width, the sampling point and the drive hold time. The controller raises the overdrive flag. A reset of standard length drops it again.

The controller learns of each slot through a one-cycle bit strobe. It learns of each bus reset through a one-cycle reset strobe. The early part of a long reset pulse also produces a strobed 0 bit, so the controller discards any partial byte when the reset strobe arrives. Command decoding, memory and the analog side of the bus are outside this block.

Top module: `onewire_slot_engine`

## Requirements
- R1: While rst_n is low and right after it rises, line_pull, bit_valid, reset_seen and overdrive are all 0.
- R2: A line low for at least 480 us at standard speed (48 us in overdrive) and then released gives a single-cycle reset_seen pulse.
- R3: After a reset ends, line_pull rises 30 us (within 15 to 60 us at standard speed) or 3 us (overdrive) after the release. It then stays high for 120 us (standard) or 12 us (overdrive), each within one microsecond plus synchronizer delay.
- R4: In a slot with tx_en low, bit_value is the line level sampled 30 us (standard) or 3 us (overdrive) after the falling edge. Low gives 0 and high gives 1. The sample is marked by a one-cycle bit_valid pulse. Bits arrive least significant first in the bench's byte checks.
- R5: In a slot that starts with tx_en high and tx_bit 0, line_pull rises within a few clocks of the falling edge and stays high for 45 us (standard) or 5 us (overdrive).
- R6: In a slot that starts with tx_en high and tx_bit 1, line_pull stays 0 for the whole slot.
- R7: An od_set pulse sets overdrive on the next clock. A reset of standard length clears it. A reset that is only of overdrive length leaves it set. If both happen in the same cycle, the reset wins.
- R8: At standard speed, a low of 470 us is a slot and not a reset, even though it exceeds the overdrive threshold. In overdrive, a 40 us low is likewise not a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| line_in | input | 1 | Raw level of the bus line |
| tx_en | input | 1 | Next slot is a read slot driven by this slave |
| tx_bit | input | 1 | Bit to send in the next read slot |
| od_set | input | 1 | Pulse to enter overdrive speed |
| line_pull | output | 1 | Open-drain enable: 1 pulls the line low |
| bit_valid | output | 1 | One-cycle strobe: bit_value holds a new slot sample |
| bit_value | output | 1 | Sampled slot level |
| reset_seen | output | 1 | One-cycle strobe on each detected bus reset |
| overdrive | output | 1 | Overdrive speed profile active |

## Verification
The checker looks at every cycle for the following:
- bit_valid and reset_seen are single-cycle strobes;
- overdrive follows od_set and standard-length resets;
- the line is released at the moment a reset is recognised.

Only the bench scenarios can show the microsecond-level behaviour. These cover:
- the presence delay and width at both speeds;
- the sampling point of write slots;
- the hold time of driven zeros;
- the silence of driven ones;
- the line between reset and slot at 470/490 us and 40/56 us.

The bench sweeps many byte patterns through write and read slots at both speeds.

// File: rtl/onewire_slot_engine.sv
module onewire_slot_engine #(
  parameter int RST_STD  = 480,
  parameter int RST_OD   = 48,
  parameter int PDLY_STD = 30,
  parameter int PDLY_OD  = 3,
  parameter int PRES_STD = 120,
  parameter int PRES_OD  = 12,
  parameter int SAMP_STD = 30,
  parameter int SAMP_OD  = 3,
  parameter int HOLD_STD = 45,
  parameter int HOLD_OD  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic line_in,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic od_set,
  output logic line_pull,
  output logic bit_valid,
  output logic bit_value,
  output logic reset_seen,
  output logic overdrive
);
  localparam int T1   = (PDLY_STD > PRES_STD) ? PDLY_STD : PRES_STD;
  localparam int T2   = (SAMP_STD > HOLD_STD) ? SAMP_STD : HOLD_STD;
  localparam int TMAX = (T1 > T2) ? T1 : T2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int LW   = $clog2(RST_STD + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_WAIT, ST_PRES} state_t;

  state_t        state;
  logic          s1, s2, prev;
  logic [LW-1:0] lowcnt;
  logic [CW-1:0] cnt;
  logic          fall, rise, rst_det, long_rst;
  logic [LW-1:0] rst_thr;
  logic [CW-1:0] pdly_t, pres_t, samp_t, hold_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= line_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign fall = prev & ~s2;
  assign rise = ~prev & s2;

  always_ff @(posedge clk) begin
    if (!rst_n || s2)
      lowcnt <= '0;
    else if (us_tick && lowcnt != LW'(RST_STD))
      lowcnt <= lowcnt + 1'b1;
  end

  assign rst_thr  = overdrive ? LW'(RST_OD) : LW'(RST_STD);
  assign long_rst = lowcnt >= LW'(RST_STD);
  assign rst_det  = rise && (lowcnt >= rst_thr);

  assign pdly_t = overdrive ? CW'(PDLY_OD) : CW'(PDLY_STD);
  assign pres_t = overdrive ? CW'(PRES_OD) : CW'(PRES_STD);
  assign samp_t = overdrive ? CW'(SAMP_OD) : CW'(SAMP_STD);
  assign hold_t = overdrive ? CW'(HOLD_OD) : CW'(HOLD_STD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      line_pull  <= 1'b0;
      bit_valid  <= 1'b0;
      bit_value  <= 1'b0;
      reset_seen <= 1'b0;
      overdrive  <= 1'b0;
    end else begin
      bit_valid  <= 1'b0;
      reset_seen <= 1'b0;
      if (rst_det) begin
        state      <= ST_WAIT;
        cnt        <= '0;
        line_pull  <= 1'b0;
        reset_seen <= 1'b1;
        overdrive  <= overdrive & ~long_rst;
      end else begin
        if (od_set) overdrive <= 1'b1;
        case (state)
          ST_IDLE: if (fall) begin
            state     <= ST_SLOT;
            cnt       <= '0;
            line_pull <= tx_en & ~tx_bit;
          end
          ST_SLOT: begin
            if (us_tick && cnt != hold_t) cnt <= cnt + 1'b1;
            if (us_tick && (cnt + 1'b1) == samp_t) begin
              bit_valid <= 1'b1;
              bit_value <= s2;
            end
            if (us_tick && (cnt + 1'b1) == hold_t) line_pull <= 1'b0;
            if (cnt == hold_t && s2) state <= ST_IDLE;
          end
          ST_WAIT: if (us_tick) begin
            if ((cnt + 1'b1) == pdly_t) begin
              state     <= ST_PRES;
              cnt       <= '0;
              line_pull <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          default: if (us_tick) begin
            if ((cnt + 1'b1) == pres_t) begin
              state     <= ST_IDLE;
              cnt       <= '0;
              line_pull <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/onewire_slot_engine_chk.sv
module onewire_slot_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic od_set,
  input logic rst_det,
  input logic long_rst,
  input logic overdrive,
  input logic bit_valid,
  input logic reset_seen,
  input logic line_pull
);
  a_r7_od_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (od_set && !rst_det) |=> overdrive);
  a_r7_std_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_det && long_rst) |=> !overdrive);
  a_r7_od_reset_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_det && !long_rst && overdrive) |=> overdrive);
  a_r4_bit_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
  a_r2_reset_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |=> !reset_seen);
  a_r3_released_at_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |-> !line_pull);
endmodule

bind onewire_slot_engine onewire_slot_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .od_set(od_set), .rst_det(rst_det),
  .long_rst(long_rst), .overdrive(overdrive), .bit_valid(bit_valid),
  .reset_seen(reset_seen), .line_pull(line_pull)
);

// File: tb/onewire_slot_engine_bench.sv
module onewire_slot_engine_bench;
  logic clk = 0, rst_n = 0, us_tick = 0;
  logic m_low = 0, tx_en = 0, tx_bit = 0, od_set = 0;
  logic line_pull, bit_valid, bit_value, reset_seen, overdrive;
  wire  line = ~(m_low | line_pull);

  int checks = 0, errors = 0, cyc = 0;
  int rx_cnt = 0, rst_cnt = 0, t_bit = 0, pull_clk = 0;
  bit pull_seen = 0, od_m = 0;
  logic [7:0] rx_sh = '0;

  onewire_slot_engine u_onewire_slot_engine (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line),
    .tx_en(tx_en), .tx_bit(tx_bit), .od_set(od_set), .line_pull(line_pull),
    .bit_valid(bit_valid), .bit_value(bit_value), .reset_seen(reset_seen),
    .overdrive(overdrive));

  always #5 clk = ~clk;
  always @(posedge clk) begin
    us_tick <= ~us_tick;
    cyc <= cyc + 1;
  end

  always @(negedge clk) if (rst_n) begin
    if (bit_valid) begin
      rx_cnt++;
      rx_sh = {bit_value, rx_sh[7:1]};
      t_bit = cyc;
    end
    if (reset_seen) rst_cnt++;
    if (line_pull) begin
      pull_seen = 1;
      pull_clk++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic us(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic bus_reset(input int low_us, output int dly_us, output int dur_us);
    int d, w;
    d = 0; w = 0;
    m_low = 1; us(low_us); m_low = 0;
    while (!line_pull && d < 400) begin @(negedge clk); d++; end
    while (line_pull && w < 600) begin @(negedge clk); w++; end
    dly_us = d / 2; dur_us = w / 2;
    us(10);
  endtask

  task automatic check_reset(input int low_us, input int pdly, input int pres, input string tag);
    int b, dl, du;
    b = rst_cnt;
    bus_reset(low_us, dl, du);
    chk(rst_cnt == b + 1, {tag, " R2 reset strobe"}, rst_cnt - b, 1);
    chk(dl >= pdly - 1 && dl <= pdly + 3, {tag, " R3 presence delay"}, dl, pdly);
    chk(du >= pres - 1 && du <= pres + 1, {tag, " R3 presence width"}, du, pres);
  endtask

  task automatic check_no_reset(input int low_us, input string tag);
    int b;
    b = rst_cnt;
    m_low = 1; us(low_us); m_low = 0;
    pull_seen = 0;
    us(150);
    chk(rst_cnt == b, {tag, " R8 no reset strobe"}, rst_cnt - b, 0);
    chk(!pull_seen, {tag, " R8 no presence"}, pull_seen, 0);
  endtask

  task automatic wslot(input bit b);
    int lo, tot;
    lo  = b ? (od_m ? 1 : 6) : (od_m ? 8 : 60);
    tot = od_m ? 12 : 70;
    m_low = 1; us(lo); m_low = 0; us(tot - lo);
  endtask

  task automatic wbyte(input logic [7:0] v);
    int b;
    b = rx_cnt;
    for (int i = 0; i < 8; i++) wslot(v[i]);
    chk(rx_cnt == b + 8, "R4 bit count", rx_cnt - b, 8);
    chk(rx_sh == v, "R4 byte received", rx_sh, v);
  endtask

  task automatic rbyte(input logic [7:0] v);
    logic [7:0] got;
    int tot, smp, hold;
    tot = od_m ? 12 : 70; smp = od_m ? 2 : 12; hold = od_m ? 5 : 45;
    got = '0;
    for (int i = 0; i < 8; i++) begin
      tx_en = 1; tx_bit = v[i];
      pull_seen = 0; pull_clk = 0;
      m_low = 1; us(1); m_low = 0;
      us(smp - 1);
      got[i] = line;
      us(tot - smp);
      tx_en = 0;
      if (v[i]) chk(!pull_seen, "R6 no drive for one", pull_seen, 0);
      else chk(pull_clk / 2 >= hold - 1 && pull_clk / 2 <= hold + 1,
               "R5 zero hold time", pull_clk / 2, hold);
    end
    chk(got == v, "R5 R6 byte on line", got, v);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    report();
  end

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    chk({line_pull, bit_valid, reset_seen, overdrive} == 4'b0, "R1 in reset",
        {line_pull, bit_valid, reset_seen, overdrive}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({line_pull, bit_valid, reset_seen, overdrive} == 4'b0, "R1 after reset",
        {line_pull, bit_valid, reset_seen, overdrive}, 0);
    us(20);

    check_reset(500, 30, 120, "std");
    check_no_reset(470, "std 470us");
    check_reset(490, 30, 120, "std 490us");

    t0 = cyc + 1;
    wslot(1'b1);
    chk(t_bit - t0 >= 2 * 29 && t_bit - t0 <= 2 * 32, "R4 std sample point",
        (t_bit - t0) / 2, 30);
    for (int v = 0; v < 256; v += 17) wbyte(8'(v));
    for (int i = 0; i < 8; i++) rbyte(8'((i * 37 + 5) % 256));

    od_set = 1; @(negedge clk); od_set = 0;
    chk(overdrive == 1, "R7 od_set", overdrive, 1);
    od_m = 1;
    check_reset(56, 3, 12, "od");
    chk(overdrive == 1, "R7 od reset keeps", overdrive, 1);
    check_no_reset(40, "od 40us");

    t0 = cyc + 1;
    wslot(1'b1);
    chk(t_bit - t0 >= 2 * 2 && t_bit - t0 <= 2 * 5, "R4 od sample point",
        (t_bit - t0) / 2, 3);
    for (int v = 0; v < 256; v++) wbyte(8'(v));
    for (int i = 0; i < 16; i++) rbyte(8'((i * 53 + 11) % 256));

    od_m = 0;
    check_reset(500, 30, 120, "std after od");
    chk(overdrive == 0, "R7 std reset clears", overdrive, 0);
    wbyte(8'hC6);
    report();
  end
endmodule